// File: doc/BRIEF.md
# Prioritized Multi-Level Interrupt Controller

This block holds a bank of interrupt levels. Each level carries one pending bit per source, and the block also keeps a per-level pending flag. Requesters can set or drop a single source bit, addressed by level and source index. A flush strobe empties the whole bank at once.

From the per-level flags, a software request vector and the low program-counter bits, the block computes a priority and a summary mask without a clock. It takes an interrupt only when that priority is above the level the core is currently running at. The decision is registered as `take_irq` and latched internally. A later `ack` strobe copies the latched priority and mask into the interrupt-ID and interrupt-summary output registers.

Defaults: 32 levels, 64 sources per level. Software requests occupy levels 1..15 and external levels occupy 16..31, with the upper bound exclusive.

Top module: `irq_level_ctrl`

## Requirements
- R1: A valid post (`post_en`, `post_lvl` < 32, `post_idx` < 64) sets that source bit. `lvl_pend[post_lvl]` reads 1 after the next rising edge.
- R2: A valid clear drops only the addressed source bit. `lvl_pend` for that level falls only once no source bit of the level is still set.
- R3: `clr_all` empties every level in one edge, so `lvl_pend` reads zero afterwards. A post in the same cycle still lands.
- R4: An interrupt can be taken only while `lvl_pend` is nonzero and `pc_lo` equals 2'b00. A software request with an empty bank takes nothing.
- R5: For each set `sw_req[i]` with 1 <= i < 16, the candidate priority is i-1+1 = i. The highest such i wins, and bit i is set in the summary mask.
- R6: For each pending level i with 16 <= i < 32, the priority becomes i, overriding any software value, and bit i is set in the summary mask. Pending levels outside both ranges affect neither the priority nor the mask.
- R7: An interrupt is taken only when the priority is nonzero and strictly greater than `cur_ipl`.
- R8: `take_irq` is the interrupt decision registered once. It changes one edge after the state that produced it.
- R9: On `ack` while a decision is latched, `int_id` and `int_sum` take the latched priority and mask at that edge. The latched flag then clears unless a new decision is made in the same cycle.
- R10: A post or clear with level >= 32 or index >= 64 changes no pending state. It raises `err` for exactly one cycle.
- R11: When a post and a clear address the same bit in the same cycle, the post wins.
- R12: `ack` while no decision is latched raises `err` for one cycle and leaves `int_id` and `int_sum` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| post_en | input | 1 | Set-source strobe |
| post_lvl | input | 6 | Level for the set |
| post_idx | input | 7 | Source index for the set |
| clr_en | input | 1 | Drop-source strobe |
| clr_lvl | input | 6 | Level for the drop |
| clr_idx | input | 7 | Source index for the drop |
| clr_all | input | 1 | Flush the whole bank |
| sw_req | input | 32 | Software request vector, one bit per level |
| cur_ipl | input | 5 | Priority level the core is running at |
| pc_lo | input | 2 | Two low bits of the program counter |
| ack | input | 1 | Commit strobe |
| take_irq | output | 1 | Registered take-interrupt decision |
| int_id | output | 5 | Committed interrupt priority |
| int_sum | output | 32 | Committed summary mask |
| lvl_pend | output | 32 | Per-level pending flags |
| err | output | 1 | One-cycle pulse for a rejected request or a stray ack |

## Verification
The priority logic is driven with several input patterns:

- **Software bits only (2 and 5), behind a pending level 0 that lies outside both ranges.** This separates the software mapping from the external mapping and shows that out-of-range pending levels stay out of the mask.
- **Software bit 15 together with external level 17.** This shows the external override and a mask that merges both sources.
- **The same request with `cur_ipl` equal to the priority and then one below it.** This exercises the strict comparison.
- **A misaligned `pc_lo` and an empty bank.** This shows both gates on taking an interrupt.
- **Two sources in one level, dropped one at a time.** This separates "bit cleared" from "level cleared".
- **Rejected addresses, post/clear collisions and stray acks.** These are observed through `lvl_pend`, `err` and the output registers.

// File: rtl/irq_pkg.sv
// Package: shared constants for the interrupt-level controller.
// Assumes: PC alignment is checked on exactly two low bits.
package irq_pkg;
    localparam int PC_ALIGN_W = 2;
    typedef logic [PC_ALIGN_W-1:0] pc_lo_t;
endpackage

// File: rtl/irq_pend_bank.sv
// Module: irq_pend_bank
// Holds one pending vector per level and reports a per-level flag that is
// the OR of its vector. Assumes requests arrive already range-checked.
// Ordering within a cycle: flush, then clear, then post (post wins).
module irq_pend_bank #(
    parameter int NUM_LVL = 32,
    parameter int NUM_SRC = 64,
    localparam int LW = $clog2(NUM_LVL),
    localparam int IW = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               post_ok,
    input  logic [LW-1:0]      post_lvl,
    input  logic [IW-1:0]      post_idx,
    input  logic               clr_ok,
    input  logic [LW-1:0]      clr_lvl,
    input  logic [IW-1:0]      clr_idx,
    input  logic               clr_all,
    output logic [NUM_LVL-1:0] lvl_stat
);
    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
        logic [NUM_SRC-1:0] vec_q;
        logic [NUM_SRC-1:0] vec_d;

        // Next-state of this level's vector.
        always_comb begin
            vec_d = clr_all ? '0 : vec_q;
            if (clr_ok && (clr_lvl == LW'(l)))
                vec_d[clr_idx] = 1'b0;
            if (post_ok && (post_lvl == LW'(l)))
                vec_d[post_idx] = 1'b1;
        end

        // Storage of this level's vector.
        always_ff @(posedge clk) begin
            if (!rst_n) vec_q <= '0;
            else        vec_q <= vec_d;
        end

        assign lvl_stat[l] = |vec_q;
    end
endmodule

// File: rtl/irq_prio_eval.sv
// Module: irq_prio_eval
// Combinational priority and summary-mask evaluation. Software levels map
// to (i - SW_LO + 1); external levels map to i and are scanned afterwards,
// so they override. Assumes both ranges lie inside [0, NUM_LVL).
module irq_prio_eval
    import irq_pkg::*;
#(
    parameter int NUM_LVL = 32,
    parameter int SW_LO   = 1,
    parameter int SW_HI   = 16,
    parameter int EXT_LO  = 16,
    parameter int EXT_HI  = 32,
    localparam int LW = $clog2(NUM_LVL)
) (
    input  logic [NUM_LVL-1:0] lvl_stat,
    input  logic [NUM_LVL-1:0] sw_req,
    input  pc_lo_t             pc_lo,
    input  logic [LW-1:0]      cur_ipl,
    output logic [LW-1:0]      ipl,
    output logic [NUM_LVL-1:0] sum,
    output logic               fire
);
    // Scan software then external ranges; last hit wins.
    always_comb begin
        ipl = '0;
        sum = '0;
        for (int i = SW_LO; i < SW_HI; i++) begin
            if (sw_req[i]) begin
                ipl    = LW'(i - SW_LO + 1);
                sum[i] = 1'b1;
            end
        end
        for (int i = EXT_LO; i < EXT_HI; i++) begin
            if (lvl_stat[i]) begin
                ipl    = LW'(i);
                sum[i] = 1'b1;
            end
        end
    end

    // Take decision: something pending, PC aligned, priority beats core.
    always_comb begin
        fire = (|lvl_stat) && (pc_lo == '0) && (ipl != '0) && (ipl > cur_ipl);
    end
endmodule

// File: rtl/irq_commit.sv
// Module: irq_commit
// Registers the take decision, latches priority/mask while taking, and
// commits them to the output registers on acknowledge. A new decision in
// the acknowledge cycle keeps the latch valid.
module irq_commit #(
    parameter int NUM_LVL = 32,
    localparam int LW = $clog2(NUM_LVL)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fire,
    input  logic [LW-1:0]      ipl,
    input  logic [NUM_LVL-1:0] sum,
    input  logic               ack,
    output logic               take_q,
    output logic               valid_q,
    output logic [LW-1:0]      lat_ipl,
    output logic [NUM_LVL-1:0] lat_sum,
    output logic [LW-1:0]      id_q,
    output logic [NUM_LVL-1:0] sum_q,
    output logic               ack_bad
);
    // Decision register, latch and commit registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_q  <= 1'b0;
            valid_q <= 1'b0;
            lat_ipl <= '0;
            lat_sum <= '0;
            id_q    <= '0;
            sum_q   <= '0;
        end else begin
            take_q <= fire;
            if (fire) begin
                lat_ipl <= ipl;
                lat_sum <= sum;
            end
            if (ack && valid_q) begin
                id_q  <= lat_ipl;
                sum_q <= lat_sum;
            end
            valid_q <= fire | (valid_q & ~ack);
        end
    end

    // Stray acknowledge detection.
    always_comb ack_bad = ack & ~valid_q;
endmodule

// File: rtl/irq_level_ctrl.sv
// Module: irq_level_ctrl (top)
// Multi-level interrupt controller: range-checks requests, stores pending
// bits, evaluates priority and commits decisions on acknowledge.
// Assumes NUM_LVL and NUM_SRC are powers of two; request addresses carry
// one extra bit so out-of-range values can be expressed and rejected.
module irq_level_ctrl
    import irq_pkg::*;
#(
    parameter int NUM_LVL = 32,
    parameter int NUM_SRC = 64,
    parameter int SW_LO   = 1,
    parameter int SW_HI   = 16,
    parameter int EXT_LO  = 16,
    parameter int EXT_HI  = 32,
    localparam int LW = $clog2(NUM_LVL),
    localparam int IW = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               post_en,
    input  logic [LW:0]        post_lvl,
    input  logic [IW:0]        post_idx,
    input  logic               clr_en,
    input  logic [LW:0]        clr_lvl,
    input  logic [IW:0]        clr_idx,
    input  logic               clr_all,
    input  logic [NUM_LVL-1:0] sw_req,
    input  logic [LW-1:0]      cur_ipl,
    input  logic [1:0]         pc_lo,
    input  logic               ack,
    output logic               take_irq,
    output logic [LW-1:0]      int_id,
    output logic [NUM_LVL-1:0] int_sum,
    output logic [NUM_LVL-1:0] lvl_pend,
    output logic               err
);
    logic               post_ok, clr_ok, post_bad, clr_bad, ack_bad;
    logic               fire, valid_q;
    logic [LW-1:0]      ipl_calc, lat_ipl;
    logic [NUM_LVL-1:0] sum_calc, lat_sum;
    logic               err_q;

    // Address range checks on incoming requests.
    always_comb begin
        post_ok  = post_en && (post_lvl < (LW+1)'(NUM_LVL)) && (post_idx < (IW+1)'(NUM_SRC));
        clr_ok   = clr_en  && (clr_lvl  < (LW+1)'(NUM_LVL)) && (clr_idx  < (IW+1)'(NUM_SRC));
        post_bad = post_en && !post_ok;
        clr_bad  = clr_en  && !clr_ok;
    end

    irq_pend_bank #(.NUM_LVL(NUM_LVL), .NUM_SRC(NUM_SRC)) bank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .post_ok  (post_ok),
        .post_lvl (post_lvl[LW-1:0]),
        .post_idx (post_idx[IW-1:0]),
        .clr_ok   (clr_ok),
        .clr_lvl  (clr_lvl[LW-1:0]),
        .clr_idx  (clr_idx[IW-1:0]),
        .clr_all  (clr_all),
        .lvl_stat (lvl_pend)
    );

    irq_prio_eval #(
        .NUM_LVL(NUM_LVL), .SW_LO(SW_LO), .SW_HI(SW_HI),
        .EXT_LO(EXT_LO), .EXT_HI(EXT_HI)
    ) eval_i (
        .lvl_stat (lvl_pend),
        .sw_req   (sw_req),
        .pc_lo    (pc_lo_t'(pc_lo)),
        .cur_ipl  (cur_ipl),
        .ipl      (ipl_calc),
        .sum      (sum_calc),
        .fire     (fire)
    );

    irq_commit #(.NUM_LVL(NUM_LVL)) commit_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fire),
        .ipl     (ipl_calc),
        .sum     (sum_calc),
        .ack     (ack),
        .take_q  (take_irq),
        .valid_q (valid_q),
        .lat_ipl (lat_ipl),
        .lat_sum (lat_sum),
        .id_q    (int_id),
        .sum_q   (int_sum),
        .ack_bad (ack_bad)
    );

    // One-cycle error pulse for rejected requests and stray acks.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= post_bad | clr_bad | ack_bad;
    end
    assign err = err_q;
endmodule

// File: rtl/irq_level_ctrl_chk.sv
// Module: irq_level_ctrl_chk
// Property checker bound to irq_level_ctrl; observes ports and the
// internal decision latch. Drives nothing.
module irq_level_ctrl_chk #(
    parameter int NUM_LVL = 32,
    parameter int NUM_SRC = 64,
    localparam int LW = $clog2(NUM_LVL),
    localparam int IW = $clog2(NUM_SRC)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               post_en,
    input logic [LW:0]        post_lvl,
    input logic [IW:0]        post_idx,
    input logic               clr_all,
    input logic [1:0]         pc_lo,
    input logic [LW-1:0]      cur_ipl,
    input logic               ack,
    input logic               take_irq,
    input logic [LW-1:0]      int_id,
    input logic [NUM_LVL-1:0] lvl_pend,
    input logic               err,
    input logic               valid_q,
    input logic [LW-1:0]      lat_ipl,
    input logic [LW-1:0]      ipl_calc
);
    // R1: a valid post shows up in the level flag.
    p_post_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (post_en && post_lvl < (LW+1)'(NUM_LVL) && post_idx < (IW+1)'(NUM_SRC))
        |=> lvl_pend[$past(post_lvl[LW-1:0])]);

    // R3: flush without a post empties the bank.
    p_flush_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_all && !post_en) |=> (lvl_pend == '0));

    // R4: a take needs an aligned PC and something pending.
    p_take_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> ($past(pc_lo) == 2'b00) && ($past(lvl_pend) != '0));

    // R7: a take needs a priority above the core's level.
    p_take_ipl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> ($past(ipl_calc) > $past(cur_ipl)));

    // R9: acknowledge commits the latched priority.
    p_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && valid_q) |=> (int_id == $past(lat_ipl)));

    // R10: out-of-range level on a post raises the error pulse.
    p_bad_post_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (post_en && post_lvl >= (LW+1)'(NUM_LVL)) |=> err);

    // R12: stray acknowledge flags an error and keeps the ID.
    p_stray_ack_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !valid_q) |=> (err && $stable(int_id)));
endmodule

bind irq_level_ctrl irq_level_ctrl_chk #(.NUM_LVL(NUM_LVL), .NUM_SRC(NUM_SRC)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .post_en  (post_en),
    .post_lvl (post_lvl),
    .post_idx (post_idx),
    .clr_all  (clr_all),
    .pc_lo    (pc_lo),
    .cur_ipl  (cur_ipl),
    .ack      (ack),
    .take_irq (take_irq),
    .int_id   (int_id),
    .lvl_pend (lvl_pend),
    .err      (err),
    .valid_q  (valid_q),
    .lat_ipl  (lat_ipl),
    .ipl_calc (ipl_calc)
);

// File: tb/irq_level_ctrl_tb_top.sv
// Scoreboard bench: driver tasks push expected values into a queue after
// each edge; a monitor pops and compares them at the falling edge.
module irq_level_ctrl_tb_top;
    localparam int NL = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        post_en = 0, clr_en = 0, clr_all = 0, ack = 0;
    logic [5:0]  post_lvl = 0, clr_lvl = 0;
    logic [6:0]  post_idx = 0, clr_idx = 0;
    logic [31:0] sw_req = 0;
    logic [4:0]  cur_ipl = 0;
    logic [1:0]  pc_lo = 0;
    logic        take_irq, err;
    logic [4:0]  int_id;
    logic [31:0] int_sum, lvl_pend;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        int          sel;
        logic [63:0] exp;
        string       req;
    } item_t;
    item_t sb_q[$];

    always #4 clk = ~clk;

    irq_level_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .post_en(post_en), .post_lvl(post_lvl), .post_idx(post_idx),
        .clr_en(clr_en), .clr_lvl(clr_lvl), .clr_idx(clr_idx),
        .clr_all(clr_all), .sw_req(sw_req), .cur_ipl(cur_ipl),
        .pc_lo(pc_lo), .ack(ack), .take_irq(take_irq), .int_id(int_id),
        .int_sum(int_sum), .lvl_pend(lvl_pend), .err(err)
    );

    function automatic logic [63:0] observe(int sel);
        case (sel)
            0: return 64'(lvl_pend);
            1: return 64'(take_irq);
            2: return 64'(int_id);
            3: return 64'(int_sum);
            default: return 64'(err);
        endcase
    endfunction

    // Monitor: compare every queued expectation at the falling edge.
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            logic [63:0] act;
            it = sb_q.pop_front();
            act = observe(it.sel);
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
            end
        end
    end

    task automatic expect_v(int sel, logic [63:0] v, string req);
        item_t it;
        it.sel = sel; it.exp = v; it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        post_en = 0; clr_en = 0; clr_all = 0; ack = 0;
    endtask

    task automatic do_post(int l, int i);
        post_en = 1; post_lvl = 6'(l); post_idx = 7'(i);
        step();
    endtask

    task automatic do_clear(int l, int i);
        clr_en = 1; clr_lvl = 6'(l); clr_idx = 7'(i);
        step();
    endtask

    task automatic do_ack();
        ack = 1;
        step();
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // Reset state
        expect_v(0, 0, "reset"); expect_v(1, 0, "reset");
        expect_v(2, 0, "reset"); expect_v(3, 0, "reset"); expect_v(4, 0, "reset");
        step();

        // R1 post, R8 registered take, R6 external priority, R9 commit
        do_post(20, 3);
        expect_v(0, 64'(32'h1 << 20), "R1"); expect_v(1, 0, "R8");
        step();
        expect_v(1, 1, "R8"); expect_v(2, 0, "R9");
        do_ack();
        expect_v(2, 20, "R9/R6"); expect_v(3, 64'(32'h1 << 20), "R9");

        // R2 level flag drops only when the vector is empty
        do_post(20, 7);
        do_clear(20, 3);
        expect_v(0, 64'(32'h1 << 20), "R2");
        do_clear(20, 7);
        expect_v(0, 0, "R2");
        step();
        expect_v(1, 0, "R2");

        // R4 gating and R5 software mapping
        sw_req = (32'h1 << 2) | (32'h1 << 5);
        step(); step();
        expect_v(1, 0, "R4 empty bank");
        do_post(0, 0);
        step();
        expect_v(1, 1, "R5");
        pc_lo = 2'b10;
        step();
        expect_v(1, 0, "R4 misaligned pc");
        pc_lo = 2'b00;
        step();
        expect_v(1, 1, "R4");
        do_ack();
        expect_v(2, 5, "R5"); expect_v(3, 64'(32'h24), "R5");

        // R6 external overrides software
        sw_req = 32'h1 << 15;
        do_post(17, 0);
        step();
        expect_v(1, 1, "R6");
        do_ack();
        expect_v(2, 17, "R6"); expect_v(3, 64'((32'h1 << 15) | (32'h1 << 17)), "R6");

        // R7 strict comparison
        cur_ipl = 5'd17;
        step();
        expect_v(1, 0, "R7 equal");
        cur_ipl = 5'd16;
        step();
        expect_v(1, 1, "R7 above");

        // R12 stray acknowledge
        cur_ipl = 5'd31;
        step();
        do_ack();
        expect_v(4, 0, "R9 ack"); expect_v(2, 17, "R9");
        do_ack();
        expect_v(4, 1, "R12"); expect_v(2, 17, "R12");
        expect_v(3, 64'((32'h1 << 15) | (32'h1 << 17)), "R12");

        // R10 out-of-range requests
        do_post(40, 0);
        expect_v(4, 1, "R10"); expect_v(0, 64'((32'h1 << 17) | 32'h1), "R10");
        do_post(3, 64);
        expect_v(4, 1, "R10"); expect_v(0, 64'((32'h1 << 17) | 32'h1), "R10");
        do_clear(17, 70);
        expect_v(4, 1, "R10"); expect_v(0, 64'((32'h1 << 17) | 32'h1), "R10");
        step();
        expect_v(4, 0, "R10 pulse");

        // R11 post wins over clear on the same bit
        post_en = 1; post_lvl = 25; post_idx = 1;
        clr_en = 1; clr_lvl = 25; clr_idx = 1;
        step();
        expect_v(0, 64'((32'h1 << 25) | (32'h1 << 17) | 32'h1), "R11");

        // R3 flush
        clr_all = 1;
        step();
        expect_v(0, 0, "R3");
        step();

        @(negedge clk);
        #1;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule